// File: doc/BRIEF.md
# Frame Window Gate

This block sits on a camera receive event stream in which every item is a frame start, frame end, line or pixel event carrying a virtual channel number and a data word. Software picks one virtual channel. The block counts the frames on that channel and forwards only the frames whose number falls inside a programmed first/last window. Events on every other channel are dropped. Each forwarded event leaves the block one clock after it enters, with its kind, channel and data unchanged.

Software can ask the block to halt. The halt never truncates a frame: the frame that is open at the time of the request finishes, and nothing after it is forwarded. After a halt, software may reprogram the window and issue a resume. Output then restarts cleanly at the next frame start. The frame that is in progress when the resume arrives is never picked up partway through.

The controller has five states:
- `ST_IDLE`: capture is off.
- `ST_WAIT`: armed, and waiting for the first frame number.
- `ST_RUN`: the window is open.
- `ST_HALT`: stopped by software.
- `ST_DONE`: the window is finished, or it cannot be reached.

The transitions are:
- **arm**: any state to `ST_WAIT`, when the enable bit goes from 0 to 1.
- **disable**: any state to `ST_IDLE`.
- **first_match**: `ST_WAIT` to `ST_RUN`, on the frame start whose number equals the first value.
- **unreachable**: `ST_WAIT` to `ST_DONE`, when last < first.
- **last_end**: `ST_RUN` to `ST_DONE`, on the frame end of the last frame, or on a frame start numbered past last.
- **halt**: `ST_WAIT`/`ST_RUN` to `ST_HALT`, at once when no frame is open, otherwise at the end of the open frame.
- **resume_run**: `ST_HALT` to `ST_RUN`, when the count has already reached the first value.
- **resume_wait**: `ST_HALT` to `ST_WAIT`, in every other case.

Top module: `frame_window_gate`

## Requirements
- R1: After reset `out_valid` is 0 and the control word at address 0 reads 0.
- R2: Register map. Address 0 is control, with these fields:
  - write and read: bit 0 = enable, bits 4:1 = selected channel;
  - read only: bit 8 = window done, bits 31:16 = frame counter;
  - write-1 pulses: bit 9 = halt, bit 10 = resume.

  Address 1 bits 15:0 hold the first frame number and address 2 bits 15:0 hold the last frame number. Address 3 reads 0.
- R3: The 16-bit counter increments on each frame start (event kind 0) of the selected channel while enabled. It is cleared to 0 when enable is written from 0 to 1, and it wraps from 0xFFFF to 0.
- R4: Events whose channel differs from the selected one, or whose channel is not allowed by the `ALLOWED_VC_MASK` parameter (channel 15 is excluded by default), are never forwarded and do not advance the counter.
- R5: After arming, frames are numbered from 1. The first forwarded frame is the one numbered with the first value. The last frame is inclusive, and its frame end (kind 1) sets window done. Later frames are not forwarded.
- R6: If last < first, no frame is forwarded and window done is set.
- R7: A halt request issued mid-frame lets the rest of that frame pass, including its frame end. Later frames are blocked, but the counter keeps counting.
- R8: After a resume, output restarts at the next frame start. Line (kind 2) and pixel (kind 3) events of a frame already in progress are not forwarded.
- R9: Line and pixel events are forwarded only inside a frame whose frame start was forwarded. Forwarded events appear one cycle later with kind, channel and data unchanged.
- R10: While enable is 0 nothing is forwarded and the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input event present |
| in_kind | input | 2 | 0 frame start, 1 frame end, 2 line, 3 pixel |
| in_vc | input | 4 | Virtual channel of the event |
| in_data | input | DATA_W | Event payload |
| out_valid | output | 1 | Forwarded event present |
| out_kind | output | 2 | Forwarded event kind |
| out_vc | output | 4 | Forwarded virtual channel |
| out_data | output | DATA_W | Forwarded payload |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The assertions check the following on every cycle:
- Nothing is forwarded while the block is disabled.
- Every forwarded event carries the selected channel.
- A frame is only ever opened by a frame start.
- No frame is open while the controller is halted.
- The done state holds until the block is re-armed.
- The counter clears on arm and wraps from 0xFFFF to 0.

Only the bench's scenarios can show which frame numbers open and close the window, that the last frame is inclusive, that a halt takes effect at a frame boundary, and that a resume skips the rest of the current frame. The bench's scoreboard also catches any event that is forwarded when it should not be.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        EV_FS   = 2'd0,
        EV_FE   = 2'd1,
        EV_LINE = 2'd2,
        EV_PIX  = 2'd3
    } ev_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUN,
        ST_HALT,
        ST_DONE
    } win_state_t;
endpackage

// File: rtl/fwg_frame_counter.sv
module fwg_frame_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear && count == '1) |=> count == '0); // R3
endmodule

// File: rtl/fwg_window_fsm.sv
module fwg_window_fsm
    import fwg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic         enabled,
    input  logic         fs_hit,
    input  logic         fe_hit,
    input  logic         stop_req,
    input  logic         restart_req,
    input  logic [W-1:0] count,
    input  logic [W-1:0] first_cnt,
    input  logic [W-1:0] last_cnt,
    output win_state_t   state,
    output logic         frame_pass,
    output logic         fs_open
);
    win_state_t nxt;
    logic       pass_n;
    logic       stop_pend;
    logic       pend_n;
    logic [W-1:0] next_num;

    assign next_num = count + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            frame_pass <= 1'b0;
            stop_pend  <= 1'b0;
        end else begin
            state      <= nxt;
            frame_pass <= pass_n;
            stop_pend  <= pend_n;
        end
    end

    always_comb begin
        nxt     = state;
        pass_n  = frame_pass;
        pend_n  = stop_pend;
        fs_open = 1'b0;
        if (arm) begin
            nxt    = ST_WAIT;
            pass_n = 1'b0;
            pend_n = 1'b0;
        end else if (!enabled) begin
            nxt    = ST_IDLE;
            pass_n = 1'b0;
            pend_n = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_WAIT: begin
                    if (last_cnt < first_cnt) begin
                        nxt = ST_DONE;
                    end else if (stop_req) begin
                        nxt = ST_HALT;
                    end else if (fs_hit && next_num == first_cnt) begin
                        nxt     = ST_RUN;
                        pass_n  = 1'b1;
                        fs_open = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (fe_hit && frame_pass) begin
                        pass_n = 1'b0;
                        if (count == last_cnt) begin
                            nxt = ST_DONE;
                        end else if (stop_pend || stop_req) begin
                            nxt    = ST_HALT;
                            pend_n = 1'b0;
                        end
                    end else if (fs_hit) begin
                        if (next_num > last_cnt) begin
                            nxt    = ST_DONE;
                            pass_n = 1'b0;
                        end else if (stop_pend || stop_req) begin
                            nxt    = ST_HALT;
                            pass_n = 1'b0;
                            pend_n = 1'b0;
                        end else begin
                            pass_n  = 1'b1;
                            fs_open = 1'b1;
                        end
                    end else if (stop_req) begin
                        if (frame_pass) pend_n = 1'b1;
                        else            nxt    = ST_HALT;
                    end
                end
                ST_HALT: begin
                    if (restart_req)
                        nxt = (count >= first_cnt) ? ST_RUN : ST_WAIT;
                end
                ST_DONE: begin
                end
            endcase
        end
    end

    AST_OPEN_ONLY_AT_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pass) |-> $past(fs_hit)); // R8
    AST_HALT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALT |-> !frame_pass); // R7
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && enabled && !arm) |=> state == ST_DONE); // R5
endmodule

// File: rtl/fwg_event_gate.sv
module fwg_event_gate
    import fwg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [1:0]        in_kind,
    input  logic [VC_W-1:0]   in_vc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              fs_open,
    input  logic              frame_pass,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [VC_W-1:0]   out_vc,
    output logic [DATA_W-1:0] out_data
);
    logic fwd;

    always_comb begin
        if (in_kind == EV_FS) fwd = hit && fs_open;
        else                  fwd = hit && frame_pass;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= '0;
            out_vc    <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= fwd;
            if (fwd) begin
                out_kind <= in_kind;
                out_vc   <= in_vc;
                out_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/frame_window_gate.sv
module frame_window_gate
    import fwg_pkg::*;
#(
    parameter int          DATA_W          = 32,
    parameter int          VC_W            = 4,
    parameter logic [15:0] ALLOWED_VC_MASK = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [VC_W-1:0]   in_vc,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [VC_W-1:0]   out_vc,
    output logic [DATA_W-1:0] out_data,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int VC_N = 1 << VC_W;

    logic              en_q;
    logic [VC_W-1:0]   vc_sel;
    logic [CNT_W-1:0]  first_cnt, last_cnt, count;
    logic              wr_ctl, arm, stop_req, restart_req;
    logic              vc_ok, hit, fs_hit, fe_hit;
    logic              frame_pass, fs_open;
    win_state_t        state;
    logic              unused_wbits;
    logic [VC_N-1:0]   allow;

    assign allow        = ALLOWED_VC_MASK[VC_N-1:0];
    assign unused_wbits = ^{reg_wdata[15:11], reg_wdata[8:5]};
    assign wr_ctl       = reg_we && reg_addr == 2'd0;
    assign arm          = wr_ctl && reg_wdata[0] && !en_q;
    assign stop_req     = wr_ctl && reg_wdata[9];
    assign restart_req  = wr_ctl && reg_wdata[10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            vc_sel    <= '0;
            first_cnt <= '0;
            last_cnt  <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                2'd0: begin
                    en_q   <= reg_wdata[0];
                    vc_sel <= reg_wdata[VC_W:1];
                end
                2'd1: first_cnt <= reg_wdata[CNT_W-1:0];
                2'd2: last_cnt  <= reg_wdata[CNT_W-1:0];
                2'd3: begin
                end
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            2'd0:    reg_rdata = {count, 7'd0, (state == ST_DONE), 3'd0, vc_sel, en_q};
            2'd1:    reg_rdata = {16'd0, first_cnt};
            2'd2:    reg_rdata = {16'd0, last_cnt};
            default: reg_rdata = 32'd0;
        endcase
    end

    assign vc_ok  = allow[vc_sel];
    assign hit    = en_q && in_valid && vc_ok && in_vc == vc_sel;
    assign fs_hit = hit && in_kind == EV_FS;
    assign fe_hit = hit && in_kind == EV_FE;

    fwg_frame_counter #(.W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .clear(arm), .inc(fs_hit), .count(count)
    );

    fwg_window_fsm #(.W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(arm), .enabled(en_q),
        .fs_hit(fs_hit), .fe_hit(fe_hit), .stop_req(stop_req),
        .restart_req(restart_req), .count(count), .first_cnt(first_cnt),
        .last_cnt(last_cnt), .state(state), .frame_pass(frame_pass),
        .fs_open(fs_open)
    );

    fwg_event_gate #(.DATA_W(DATA_W), .VC_W(VC_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .hit(hit), .in_kind(in_kind),
        .in_vc(in_vc), .in_data(in_data), .fs_open(fs_open),
        .frame_pass(frame_pass), .out_valid(out_valid), .out_kind(out_kind),
        .out_vc(out_vc), .out_data(out_data)
    );

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !out_valid); // R10
    AST_VC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_vc == $past(vc_sel)); // R4
endmodule

// File: tb/frame_window_gate_tb_top.sv
module frame_window_gate_tb_top;
    localparam int DATA_W = 32;

    typedef struct {
        logic [1:0]        kind;
        logic [3:0]        vc;
        logic [DATA_W-1:0] data;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [1:0]        in_kind = '0;
    logic [3:0]        in_vc = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [1:0]        out_kind;
    logic [3:0]        out_vc;
    logic [DATA_W-1:0] out_data;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;

    int   checks = 0;
    int   errors = 0;
    int   seq = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    frame_window_gate #(.DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_vc(in_vc), .in_data(in_data), .out_valid(out_valid),
        .out_kind(out_kind), .out_vc(out_vc), .out_data(out_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL unexpected output (R9/R4) kind=%0d vc=%0d data=%h expected none",
                         out_kind, out_vc, out_data);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.kind !== out_kind || e.vc !== out_vc || e.data !== out_data) begin
                    errors++;
                    $display("FAIL %s got kind=%0d vc=%0d data=%h expected kind=%0d vc=%0d data=%h",
                             e.tag, out_kind, out_vc, out_data, e.kind, e.vc, e.data);
                end
            end
        end
    end

    task automatic ev(input logic [1:0] k, input logic [3:0] vc, input bit pass, input string tag);
        exp_t e;
        @(negedge clk);
        seq++;
        in_valid = 1'b1; in_kind = k; in_vc = vc; in_data = 32'hA500_0000 + seq;
        if (pass) begin
            e.kind = k; e.vc = vc; e.data = in_data; e.tag = tag;
            q.push_back(e);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic frame(input logic [3:0] vc, input bit pass, input string tag);
        ev(2'd0, vc, pass, tag);
        ev(2'd2, vc, pass, tag);
        ev(2'd3, vc, pass, tag);
        ev(2'd3, vc, pass, tag);
        ev(2'd1, vc, pass, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s reg[%0d] got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic drain_chk(input string tag);
        repeat (2) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL %s missing outputs got %0d pending expected 0", tag, q.size());
            q.delete();
        end
    endtask

    task automatic fs_burst(input int n, input logic [3:0] vc);
        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'd0; in_vc = vc;
        repeat (n) @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_valid got %b expected 0", out_valid);
        end
        rd_chk(2'd0, 32'h0, "R1 ctrl after reset");

        // R2/R5: window 2..3 on vc 2
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'h0005);
        rd_chk(2'd1, 32'd2, "R2 first readback");
        rd_chk(2'd2, 32'd3, "R2 last readback");
        rd_chk(2'd0, 32'h0000_0005, "R2 R3 ctrl after arm");
        frame(4'd2, 1'b0, "R5 frame1 blocked");
        frame(4'd1, 1'b0, "R4 other vc");
        frame(4'd2, 1'b1, "R5 frame2 first");
        frame(4'd2, 1'b1, "R5 frame3 last inclusive");
        frame(4'd2, 1'b0, "R5 frame4 after last");
        drain_chk("R5 window");
        rd_chk(2'd0, 32'h0004_0105, "R5 R3 done and count");
        rd_chk(2'd3, 32'h0, "R2 addr3");

        // R6: last < first
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h0005);
        rd_chk(2'd0, 32'h0000_0105, "R6 done, R3 cleared");
        frame(4'd2, 1'b0, "R6 no output");
        drain_chk("R6");

        // R7: halt mid-frame
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd100);
        wr(2'd0, 16'h0005);
        frame(4'd2, 1'b1, "R7 frame1");
        ev(2'd0, 4'd2, 1'b1, "R7 frame2 start");
        ev(2'd2, 4'd2, 1'b1, "R7 frame2 line");
        wr(2'd0, 16'h0205);
        ev(2'd3, 4'd2, 1'b1, "R7 rest of frame");
        ev(2'd1, 4'd2, 1'b1, "R7 frame end");
        frame(4'd2, 1'b0, "R7 after halt");
        drain_chk("R7");
        rd_chk(2'd0, 32'h0003_0005, "R7 count keeps running");

        // R8: resume mid-frame
        ev(2'd0, 4'd2, 1'b0, "R8 frame4 start halted");
        wr(2'd0, 16'h0405);
        ev(2'd2, 4'd2, 1'b0, "R8 partial frame line");
        ev(2'd3, 4'd2, 1'b0, "R8 partial frame pixel");
        ev(2'd1, 4'd2, 1'b0, "R8 partial frame end");
        frame(4'd2, 1'b1, "R8 R9 next frame");
        drain_chk("R8");
        rd_chk(2'd0, 32'h0005_0005, "R8 count");

        // R9: line/pixel outside an opened frame
        ev(2'd2, 4'd2, 1'b0, "R9 stray line");
        ev(2'd3, 4'd2, 1'b0, "R9 stray pixel");
        drain_chk("R9");

        // R10: disabled
        wr(2'd0, 16'h0004);
        frame(4'd2, 1'b0, "R10 disabled");
        drain_chk("R10");
        rd_chk(2'd0, 32'h0005_0004, "R10 count held");

        // R4: channel not allowed
        wr(2'd0, 16'h001F);
        frame(4'd15, 1'b0, "R4 disallowed vc");
        drain_chk("R4");
        rd_chk(2'd0, 32'h0000_001F, "R4 not counted");

        // R3: wrap
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h0005);
        fs_burst(65535, 4'd2);
        rd_chk(2'd0, 32'hFFFF_0105, "R3 count max");
        fs_burst(1, 4'd2);
        rd_chk(2'd0, 32'h0000_0105, "R3 wrap");
        drain_chk("R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule